// File: doc/BRIEF.md
# Doorbell Interrupt Controller with Grouped Vectors

This block holds the doorbell state for one side of a two-host bridge. A 16-bit status register collects pending doorbell events. A 16-bit mask register decides which of those events may raise an interrupt. The peer host rings doorbells through a dedicated ring port. The local host can ring them too, through a write-only register. Either way, one ring sets a whole group of five status bits at once. The top status bit is kept for link-change events, and it is set on every edge of a link-status input.

The pending bits (status AND NOT mask) are combined into four registered vector outputs. Three data vectors each cover one five-bit group. The fourth vector carries only the link bit. A single legacy interrupt output ORs every pending unmasked bit. Software clears events by writing ones to the status register. To enable a vector, software clears the lowest mask bit of that vector's group. Masked events still latch, so nothing is lost while a vector is disabled.

Top module: `dbell_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the status register to 0x0000 and the mask register to 0x7FFF, so only bit 15 is unmasked. It also drives every vector output and the legacy output low.
- R2: The register port uses these offsets. Offset 0x0 reads the status register, offset 0x2 reads and writes the mask register, and offset 0x4 is the ring register, which reads as zero. Read data appears on reg_rdata one cycle after the cycle in which reg_rd_en is high.
- R3: A write to offset 0x0 clears each status bit where reg_wdata holds 1 and leaves unchanged each bit where it holds 0.
- R4: A cycle with ring_valid high and ring_grp = n, for n in 0..2, sets status bits 5n+4 down to 5n. A ring_grp value of 3 changes nothing.
- R5: A write to offset 0x4 sets group n (bits 5n+4:5n) for each n in 0..2 where reg_wdata bit n is 1. All other reg_wdata bits have no effect.
- R6: Vector output irq_vec[n], for n in 0..2, is the OR of status AND NOT mask over bits 5n+4:5n. irq_vec[3] follows status bit 15 AND NOT mask bit 15. All vector outputs are registered and change one cycle after the state they reflect.
- R7: A status bit is set even while it is masked. It drives its vector as soon as its mask bit is cleared.
- R8: When a ring and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Each rising edge and each falling edge of link_in sets status bit 15.
- R10: irq_legacy is the registered OR of all status bits that are not masked.
- R11: Clearing only mask bit 5n, after a ring of group n, raises irq_vec[n]. Setting that mask bit again lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| ring_valid | input | 1 | Peer ring request |
| ring_grp | input | 2 | Group index rung by the peer |
| link_in | input | 1 | Link-status level |
| irq_vec | output | 4 | Per-vector interrupts; bit 3 is the link vector |
| irq_legacy | output | 1 | OR of all pending unmasked bits |

## Verification
The bound checker covers several behaviours on every cycle:
- the reset values of both registers;
- a peer ring filling its whole group on the next cycle, even when a clear of the same bits arrives in that cycle;
- link edges landing in bit 15;
- the legacy output tracking the pending set;
- the link vector depending on bit 15 alone;
- the ring offset reading as zero.

Some behaviours only the directed scenarios can show. These are the exact mapping from each group to its vector, the mask bit 5n convention, and masked events appearing once unmasked. The scenarios also cover writes that clear some bits while leaving others, ring-register bits above bit 2 having no effect, and a group index of 3 being ignored.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int OFS_STAT = 0;
  localparam int OFS_MASK = 2;
  localparam int OFS_RING = 4;

  // bit pattern of group n when groups are w bits wide
  function automatic logic [31:0] grp_bits(input int n, input int w);
    logic [31:0] one_grp;
    one_grp = (32'd1 << w) - 32'd1;
    return one_grp << (w * n);
  endfunction
endpackage

// File: rtl/dbell_link_edge.sv
module dbell_link_edge (
  input  logic clk,
  input  logic rst,
  input  logic link_in,
  output logic link_evt
);
  logic link_prev;

  always_ff @(posedge clk) begin
    // under reset the history follows the input, so no edge is invented
    link_prev <= link_in;
  end

  assign link_evt = !rst && (link_in != link_prev);
endmodule

// File: rtl/dbell_ring_dec.sv
module dbell_ring_dec #(
  parameter int DB_W   = 16,
  parameter int GRP_W  = 5,
  parameter int N_DVEC = 3,
  parameter int RING_W = 2
) (
  input  logic              ring_valid,
  input  logic [RING_W-1:0] ring_grp,
  input  logic              loc_ring_en,
  input  logic [N_DVEC-1:0] loc_ring_grps,
  input  logic              link_evt,
  output logic [DB_W-1:0]   set_bits
);
  import dbell_pkg::*;

  always_comb begin
    set_bits = '0;
    for (int n = 0; n < N_DVEC; n++) begin
      if ((ring_valid && int'(ring_grp) == n) || (loc_ring_en && loc_ring_grps[n]))
        set_bits = set_bits | DB_W'(grp_bits(n, GRP_W));
    end
    if (link_evt)
      set_bits[DB_W-1] = 1'b1;
  end
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs #(
  parameter int DB_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DB_W-1:0]   wdata,
  input  logic [DB_W-1:0]   set_bits,
  output logic [DB_W-1:0]   status_q,
  output logic [DB_W-1:0]   mask_q,
  output logic [DB_W-1:0]   rdata
);
  import dbell_pkg::*;

  localparam logic [DB_W-1:0] RST_MASK = {1'b0, {(DB_W-1){1'b1}}};

  logic            hit_stat;
  logic            hit_mask;
  logic [DB_W-1:0] clr_bits;

  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_mask = (addr == ADDR_W'(OFS_MASK));
  assign clr_bits = (wr_en && hit_stat) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= RST_MASK;
    end else begin
      // setting is applied after clearing so a same-cycle event survives
      status_q <= (status_q & ~clr_bits) | set_bits;
      if (wr_en && hit_mask)
        mask_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en) begin
      if (hit_stat)
        rdata <= status_q;
      else if (hit_mask)
        rdata <= mask_q;
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/dbell_vec_agg.sv
module dbell_vec_agg #(
  parameter int DB_W   = 16,
  parameter int GRP_W  = 5,
  parameter int N_DVEC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DB_W-1:0] status_q,
  input  logic [DB_W-1:0] mask_q,
  output logic [N_DVEC:0] irq_vec,
  output logic            irq_legacy
);
  import dbell_pkg::*;

  logic [DB_W-1:0] pend;
  assign pend = status_q & ~mask_q;

  for (genvar n = 0; n < N_DVEC; n++) begin : g_data_vec
    localparam logic [DB_W-1:0] GM = DB_W'(grp_bits(n, GRP_W));
    always_ff @(posedge clk) begin
      if (rst) irq_vec[n] <= 1'b0;
      else     irq_vec[n] <= |(pend & GM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_vec[N_DVEC] <= 1'b0;
      irq_legacy      <= 1'b0;
    end else begin
      irq_vec[N_DVEC] <= pend[DB_W-1];
      irq_legacy      <= |pend;
    end
  end
endmodule

// File: rtl/dbell_irq_ctrl.sv
module dbell_irq_ctrl #(
  parameter int DB_W   = 16,
  parameter int GRP_W  = 5,
  parameter int N_DVEC = 3,
  parameter int ADDR_W = 3,
  parameter int RING_W = $clog2(N_DVEC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DB_W-1:0]   reg_wdata,
  output logic [DB_W-1:0]   reg_rdata,
  input  logic              ring_valid,
  input  logic [RING_W-1:0] ring_grp,
  input  logic              link_in,
  output logic [N_DVEC:0]   irq_vec,
  output logic              irq_legacy
);
  import dbell_pkg::*;

  logic            link_evt;
  logic            loc_ring_en;
  logic [DB_W-1:0] set_bits;
  logic [DB_W-1:0] status_q;
  logic [DB_W-1:0] mask_q;

  assign loc_ring_en = reg_wr_en && (reg_addr == ADDR_W'(OFS_RING));

  dbell_link_edge u_link (
    .clk      (clk),
    .rst      (rst),
    .link_in  (link_in),
    .link_evt (link_evt)
  );

  dbell_ring_dec #(
    .DB_W(DB_W), .GRP_W(GRP_W), .N_DVEC(N_DVEC), .RING_W(RING_W)
  ) u_dec (
    .ring_valid    (ring_valid),
    .ring_grp      (ring_grp),
    .loc_ring_en   (loc_ring_en),
    .loc_ring_grps (reg_wdata[N_DVEC-1:0]),
    .link_evt      (link_evt),
    .set_bits      (set_bits)
  );

  dbell_regs #(.DB_W(DB_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .set_bits (set_bits),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rdata    (reg_rdata)
  );

  dbell_vec_agg #(.DB_W(DB_W), .GRP_W(GRP_W), .N_DVEC(N_DVEC)) u_agg (
    .clk        (clk),
    .rst        (rst),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .irq_vec    (irq_vec),
    .irq_legacy (irq_legacy)
  );
endmodule

// File: rtl/dbell_irq_chk.sv
module dbell_irq_chk #(
  parameter int DB_W   = 16,
  parameter int GRP_W  = 5,
  parameter int N_DVEC = 3,
  parameter int ADDR_W = 3,
  parameter int RING_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DB_W-1:0]   reg_rdata,
  input logic              ring_valid,
  input logic [RING_W-1:0] ring_grp,
  input logic              link_in,
  input logic [DB_W-1:0]   status_q,
  input logic [DB_W-1:0]   mask_q,
  input logic [N_DVEC:0]   irq_vec,
  input logic              irq_legacy
);
  localparam logic [DB_W-1:0] LOW_GRP  = DB_W'((1 << GRP_W) - 1);
  localparam logic [DB_W-1:0] RST_MASK = {1'b0, {(DB_W-1){1'b1}}};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == RST_MASK && status_q == '0 && irq_vec == '0 && !irq_legacy));

  // R4 R8
  ring_fills_grp_chk: assert property (@(posedge clk) disable iff (rst)
    (ring_valid && int'(ring_grp) < N_DVEC) |=>
      (((status_q >> (GRP_W * int'($past(ring_grp)))) & LOW_GRP) == LOW_GRP));

  // R9
  link_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_in != $past(link_in)) |=> status_q[DB_W-1]);

  // R10
  legacy_up_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ~mask_q)) |=> irq_legacy);

  // R10
  legacy_down_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & ~mask_q)) |=> !irq_legacy);

  // R6
  link_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_vec[N_DVEC] |-> $past(status_q[DB_W-1] && !mask_q[DB_W-1]));

  // R2
  ring_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(4)) |=> reg_rdata == '0);
endmodule

bind dbell_irq_ctrl dbell_irq_chk #(
  .DB_W(DB_W), .GRP_W(GRP_W), .N_DVEC(N_DVEC), .ADDR_W(ADDR_W), .RING_W(RING_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd_en  (reg_rd_en),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .ring_valid (ring_valid),
  .ring_grp   (ring_grp),
  .link_in    (link_in),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq_vec    (irq_vec),
  .irq_legacy (irq_legacy)
);

// File: tb/tb_dbell_irq_ctrl.sv
module tb_dbell_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ring_valid = 1'b0;
  logic [1:0]  ring_grp = '0;
  logic        link_in = 1'b0;
  logic [3:0]  irq_vec;
  logic        irq_legacy;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dbell_irq_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ring_valid(ring_valid), .ring_grp(ring_grp), .link_in(link_in),
    .irq_vec(irq_vec), .irq_legacy(irq_legacy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ring(input logic [1:0] g);
    @(negedge clk);
    ring_valid = 1'b1; ring_grp = g;
    @(negedge clk);
    ring_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clean();
    wr(3'h0, 16'hFFFF);
    wr(3'h2, 16'h7FFF);
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq_vec", {12'h0, irq_vec}, 16'h0);
    chk("R1 irq_legacy", {15'h0, irq_legacy}, 16'h0);
    rd(3'h0, v); chk("R1 status", v, 16'h0000);
    rd(3'h2, v); chk("R1 mask", v, 16'h7FFF);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    wr(3'h2, 16'h1234);
    rd(3'h2, v); chk("R2 mask rw", v, 16'h1234);
    rd(3'h4, v); chk("R2 ring reads zero", v, 16'h0000);
    wr(3'h2, 16'h7FFF);
  endtask

  task automatic t_ring_port();
    logic [15:0] v;
    ring(2'd1);
    rd(3'h0, v); chk("R4 ring grp1", v, 16'h03E0);
    ring(2'd3);
    rd(3'h0, v); chk("R4 grp3 ignored", v, 16'h03E0);
    ring(2'd2);
    rd(3'h0, v); chk("R4 ring grp2", v, 16'h7FE0);
    clean();
  endtask

  task automatic t_ring_reg();
    logic [15:0] v;
    wr(3'h4, 16'h0005);
    rd(3'h0, v); chk("R5 local ring grps0,2", v, 16'h7C1F);
    wr(3'h4, 16'hFFF8);
    rd(3'h0, v); chk("R5 upper bits ignored", v, 16'h7C1F);
    clean();
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    ring(2'd0);
    wr(3'h0, 16'h0005);
    rd(3'h0, v); chk("R3 partial clear", v, 16'h001A);
    wr(3'h0, 16'h0000);
    rd(3'h0, v); chk("R3 zero write keeps", v, 16'h001A);
    clean();
  endtask

  task automatic t_vec_map();
    logic [15:0] v;
    ring(2'd0); ring(2'd2);
    wr(3'h2, 16'h0000);
    settle();
    chk("R6 vec0 and vec2", {12'h0, irq_vec}, 16'h0005);
    wr(3'h0, 16'h0400);
    settle();
    chk("R6 group still pending", {12'h0, irq_vec}, 16'h0005);
    wr(3'h0, 16'h7800);
    settle();
    chk("R6 vec2 drops", {12'h0, irq_vec}, 16'h0001);
    rd(3'h0, v); chk("R6 status", v, 16'h001F);
    clean();
  endtask

  task automatic t_mask_pending();
    logic [15:0] v;
    ring(2'd1);
    settle();
    chk("R7 masked no vec", {12'h0, irq_vec}, 16'h0);
    chk("R7 masked no legacy", {15'h0, irq_legacy}, 16'h0);
    wr(3'h2, 16'h7FDF);
    settle();
    chk("R11 unmask bit5 raises vec1", {12'h0, irq_vec}, 16'h0002);
    chk("R10 legacy up", {15'h0, irq_legacy}, 16'h1);
    wr(3'h2, 16'h7FFF);
    settle();
    chk("R11 remask lowers vec1", {12'h0, irq_vec}, 16'h0);
    rd(3'h0, v); chk("R7 status kept", v, 16'h03E0);
    clean();
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    ring(2'd0);
    @(negedge clk);
    ring_valid = 1'b1; ring_grp = 2'd0;
    reg_wr_en = 1'b1; reg_addr = 3'h0; reg_wdata = 16'h001F;
    @(negedge clk);
    ring_valid = 1'b0; reg_wr_en = 1'b0;
    rd(3'h0, v); chk("R8 set beats clear", v, 16'h001F);
    clean();
  endtask

  task automatic t_link();
    logic [15:0] v;
    @(negedge clk); link_in = 1'b1;
    settle();
    rd(3'h0, v); chk("R9 rising edge", v, 16'h8000);
    chk("R6 vec3 link", {12'h0, irq_vec}, 16'h0008);
    chk("R10 legacy link", {15'h0, irq_legacy}, 16'h1);
    wr(3'h0, 16'h8000);
    settle();
    rd(3'h0, v); chk("R9 cleared, level held", v, 16'h0000);
    chk("R6 vec3 low", {12'h0, irq_vec}, 16'h0);
    @(negedge clk); link_in = 1'b0;
    settle();
    rd(3'h0, v); chk("R9 falling edge", v, 16'h8000);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_regmap();
    t_ring_port();
    t_ring_reg();
    t_w1c();
    t_vec_map();
    t_mask_pending();
    t_set_wins();
    t_link();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule